// File: doc/BRIEF.md
# Keyed flash command and status unit

This block is the register front end of an embedded flash controller, reached over a simple word-addressed bus. Software writes a command word into the command register. The word must carry a key byte, a page number and an operation code. The unit checks the key, the code and the page range, and it checks the page against sixteen region lock bits. It then either rejects the command with an error flag or starts it. While a command runs, the unit reports busy.

The flash array is not modelled physically. A fixed busy countdown stands in for its timing, and a one-bit-per-page "erased" memory, plus one bit for the user page, stands in for its contents. A quick-read command reports that memory back through a status bit. The status register shows ready, both error flags, a sticky security flag, the quick-read result and the sixteen lock bits. Reading the status register clears the two error flags. A level interrupt combines ready, lock error and programming error, each under its own enable bit in the control register.

Register word addresses: 0 is control, 1 is command (reads as zero), 2 is status and 3 is parameter.

Top module: `flash_cmd_unit`

## Requirements
- R1: A command word carries the key 0xA5 in bits 31:24, the page in bits 23:8 and the operation code in bits 5:0. A command write with any other key changes no flash or lock state, sets the programming-error flag (status bit 3) and leaves ready (status bit 0) high.
- R2: An accepted command drops ready starting the cycle after the write, and ready stays low for exactly BUSY_LEN cycles.
- R3: A command write that arrives while ready is low is ignored completely: no error flag is raised and no state changes.
- R4: The following commands are not executed and set the programming-error flag:
  - a command whose code is above 0x11;
  - a page-addressed command (codes 1, 2, 4, 5, 12) whose page is not below the page count.
- R5: Lock (code 4) and unlock (code 5) set and clear, respectively, the lock bit of region page/(pages/16). Lock bits appear in status bits 16+region.
- R6: Page write (code 1) or page erase (code 2) to a locked region, or erase-all (code 6) while any region is locked, does not run. It sets lock error (status bit 2), and ready is low for one cycle only.
- R7: Page erase marks the page erased, page write marks it programmed and erase-all marks every page erased. Quick page read (code 12) copies the page's erased state into status bit 5. At reset, all pages read as erased.
- R8: User-page erase (code 14) and user-page write (code 13) set and clear the user-page erased state. User-page quick read (code 15) copies that state into status bit 5.
- R9: Set-security (code 9) sets status bit 4, which stays set until reset and is not cleared by a status read.
- R10: A status read (bus_rd at address 2) clears both error flags on the following edge. An error raised in the same cycle takes priority over the clear.
- R11: The control register resets to zero and keeps only bits 0, 2, 3, 4, 6 and 7; all other bits read zero.
- R12: irq is high when any of these holds:
  - control bit 0 is set and ready is high;
  - control bit 2 is set and lock error is set;
  - control bit 3 is set and programming error is set.
- R13: The parameter register reads SIZE_SEL in bits 3:0 and zero elsewhere. The page count is the selected size in KiB times two (512-byte pages).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (status read clears errors) |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Level interrupt |

## Verification
Assertions cover the behaviour that can be checked on every cycle:
- the busy countdown holds until it expires and never starts by itself;
- a wrong-key write keeps ready high and raises the programming error;
- a write during busy leaves the lock bits untouched;
- a locked erase or write always yields a lock error and a single busy cycle;
- a status read without a new error clears both flags.

Only the bench scenarios can show the full behaviour:
- the exact busy length;
- region arithmetic for specific pages;
- the erased-state history seen through quick reads;
- the control mask;
- how irq follows each enable.

// File: rtl/fcsu_pkg.sv
package fcsu_pkg;

    localparam logic [7:0] CMD_KEY = 8'hA5;

    localparam logic [1:0] A_CTRL   = 2'd0;
    localparam logic [1:0] A_CMD    = 2'd1;
    localparam logic [1:0] A_STATUS = 2'd2;
    localparam logic [1:0] A_PARAM  = 2'd3;

    localparam logic [31:0] CTRL_KEEP = 32'h0000_00DD;

    typedef enum logic [5:0] {
        OP_NOP         = 6'd0,
        OP_WRITE_PG    = 6'd1,
        OP_ERASE_PG    = 6'd2,
        OP_CLR_BUF     = 6'd3,
        OP_LOCK        = 6'd4,
        OP_UNLOCK      = 6'd5,
        OP_ERASE_ALL   = 6'd6,
        OP_FUSE_WR     = 6'd7,
        OP_FUSE_ER     = 6'd8,
        OP_SET_SEC     = 6'd9,
        OP_FUSE_PROG   = 6'd10,
        OP_FUSE_ER_ALL = 6'd11,
        OP_QREAD       = 6'd12,
        OP_USR_WR      = 6'd13,
        OP_USR_ER      = 6'd14,
        OP_USR_QREAD   = 6'd15,
        OP_HS_ON       = 6'd16,
        OP_HS_OFF      = 6'd17
    } op_e;

    typedef struct packed {
        logic        key_ok;
        logic        op_valid;
        logic        page_ok;
        op_e         op;
        logic [15:0] page;
    } cmd_t;

    function automatic int unsigned size_kib(input logic [3:0] sel);
        case (sel)
            4'd0:    return 4;
            4'd1:    return 8;
            4'd2:    return 16;
            4'd3:    return 32;
            4'd4:    return 48;
            4'd5:    return 64;
            4'd6:    return 96;
            4'd7:    return 128;
            4'd8:    return 192;
            4'd9:    return 256;
            4'd10:   return 384;
            4'd11:   return 512;
            4'd12:   return 768;
            4'd13:   return 1024;
            default: return 2048;
        endcase
    endfunction

    function automatic logic uses_page(input op_e op);
        return (op == OP_WRITE_PG) || (op == OP_ERASE_PG) || (op == OP_LOCK) ||
               (op == OP_UNLOCK) || (op == OP_QREAD);
    endfunction

endpackage

// File: rtl/fcsu_cmd_decode.sv
module fcsu_cmd_decode
    import fcsu_pkg::*;
#(
    parameter int unsigned PAGES = 256
) (
    input  logic [31:0] word,
    output cmd_t        cmd
);
    always_comb begin
        cmd.key_ok   = (word[31:24] == CMD_KEY);
        cmd.op_valid = (word[5:0] <= 6'd17);
        cmd.op       = op_e'(word[5:0]);
        cmd.page     = word[23:8];
        cmd.page_ok  = (32'(word[23:8]) < PAGES);
    end
endmodule

// File: rtl/fcsu_busy_timer.sv
module fcsu_busy_timer #(
    parameter int unsigned BUSY_LEN = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic short_run,
    output logic busy
);
    localparam int unsigned CNT_W = $clog2(BUSY_LEN + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_LEN - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= short_run ? '0 : LOAD;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != '0) |=> busy);
    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> !busy);
    p_short_r6: assert property (@(posedge clk) disable iff (rst)
        (start && short_run) |=> (busy && cnt == '0));
endmodule

// File: rtl/fcsu_lock_bank.sv
module fcsu_lock_bank #(
    parameter int unsigned PER_REGION = 16,
    parameter int unsigned PG_W       = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PG_W-1:0] page,
    input  logic            set_en,
    input  logic            clr_en,
    output logic [15:0]     locks,
    output logic            page_locked
);
    logic [3:0] region;

    assign region      = 4'((32'(page)) / PER_REGION);
    assign page_locked = locks[region];

    for (genvar g = 0; g < 16; g++) begin : g_region
        always_ff @(posedge clk) begin
            if (rst)                                 locks[g] <= 1'b0;
            else if (set_en && region == 4'(g))      locks[g] <= 1'b1;
            else if (clr_en && region == 4'(g))      locks[g] <= 1'b0;
        end
    end

    always_comb begin
        if (!rst) p_set_clr_excl_r5: assert (!(set_en && clr_en));
    end

    p_one_region_r5: assert property (@(posedge clk) disable iff (rst)
        (set_en || clr_en) |=> $countones(locks ^ $past(locks)) <= 1);
endmodule

// File: rtl/fcsu_page_state.sv
module fcsu_page_state #(
    parameter int unsigned PAGES = 256,
    parameter int unsigned PG_W  = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PG_W-1:0] page,
    input  logic            erase_pg,
    input  logic            write_pg,
    input  logic            erase_all,
    input  logic            usr_erase,
    input  logic            usr_write,
    output logic            page_erased,
    output logic            usr_erased
);
    logic [PAGES-1:0] erased;

    assign page_erased = erased[page];

    always_ff @(posedge clk) begin
        if (rst) begin
            erased     <= '1;
            usr_erased <= 1'b1;
        end else begin
            if (erase_all)     erased       <= '1;
            else if (erase_pg) erased[page] <= 1'b1;
            else if (write_pg) erased[page] <= 1'b0;
            if (usr_erase)      usr_erased <= 1'b1;
            else if (usr_write) usr_erased <= 1'b0;
        end
    end

    always_comb begin
        if (!rst) p_one_array_op_r7: assert ($onehot0({erase_pg, write_pg, erase_all}));
    end

    p_write_clears_r7: assert property (@(posedge clk) disable iff (rst)
        write_pg |=> !erased[$past(page)]);
endmodule

// File: rtl/flash_cmd_unit.sv
module flash_cmd_unit
    import fcsu_pkg::*;
#(
    parameter int unsigned SIZE_SEL = 7,
    parameter int unsigned BUSY_LEN = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    localparam int unsigned PAGES      = size_kib(4'(SIZE_SEL)) * 2;
    localparam int unsigned PER_REGION = (PAGES / 16 > 0) ? PAGES / 16 : 1;
    localparam int unsigned PG_W       = $clog2(PAGES);

    cmd_t            cmd;
    logic            busy, ready;
    logic            cmd_wr, issue, legal, accept, locked_hit, run, prog_fault;
    logic            stat_rd;
    logic [31:0]     ctrl_q;
    logic            lk_err, pg_err, sec_q, qres_q;
    logic [15:0]     locks;
    logic            page_locked, page_erased, usr_erased;
    logic [PG_W-1:0] pidx;

    assign ready   = !busy;
    assign cmd_wr  = bus_wr && (bus_addr == A_CMD);
    assign stat_rd = bus_rd && (bus_addr == A_STATUS);
    assign issue   = cmd_wr && ready;
    assign pidx    = cmd.page[PG_W-1:0];

    fcsu_cmd_decode #(.PAGES(PAGES)) u_dec (.word(bus_wdata), .cmd(cmd));

    always_comb begin
        legal      = cmd.key_ok && cmd.op_valid && (cmd.page_ok || !uses_page(cmd.op));
        accept     = issue && legal;
        prog_fault = issue && !legal;
        locked_hit = accept &&
                     ((((cmd.op == OP_WRITE_PG) || (cmd.op == OP_ERASE_PG)) && page_locked) ||
                      ((cmd.op == OP_ERASE_ALL) && (|locks)));
        run        = accept && !locked_hit;
    end

    fcsu_busy_timer #(.BUSY_LEN(BUSY_LEN)) u_timer (
        .clk(clk), .rst(rst), .start(accept), .short_run(locked_hit), .busy(busy)
    );

    fcsu_lock_bank #(.PER_REGION(PER_REGION), .PG_W(PG_W)) u_locks (
        .clk(clk), .rst(rst), .page(pidx),
        .set_en(run && cmd.op == OP_LOCK),
        .clr_en(run && cmd.op == OP_UNLOCK),
        .locks(locks), .page_locked(page_locked)
    );

    fcsu_page_state #(.PAGES(PAGES), .PG_W(PG_W)) u_pages (
        .clk(clk), .rst(rst), .page(pidx),
        .erase_pg(run && cmd.op == OP_ERASE_PG),
        .write_pg(run && cmd.op == OP_WRITE_PG),
        .erase_all(run && cmd.op == OP_ERASE_ALL),
        .usr_erase(run && cmd.op == OP_USR_ER),
        .usr_write(run && cmd.op == OP_USR_WR),
        .page_erased(page_erased), .usr_erased(usr_erased)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            lk_err <= 1'b0;
            pg_err <= 1'b0;
            sec_q  <= 1'b0;
            qres_q <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == A_CTRL) ctrl_q <= bus_wdata & CTRL_KEEP;
            if (locked_hit)   lk_err <= 1'b1;
            else if (stat_rd) lk_err <= 1'b0;
            if (prog_fault)   pg_err <= 1'b1;
            else if (stat_rd) pg_err <= 1'b0;
            if (run && cmd.op == OP_SET_SEC)   sec_q  <= 1'b1;
            if (run && cmd.op == OP_QREAD)     qres_q <= page_erased;
            if (run && cmd.op == OP_USR_QREAD) qres_q <= usr_erased;
        end
    end

    always_comb begin
        case (bus_addr)
            A_CTRL:   bus_rdata = ctrl_q;
            A_STATUS: bus_rdata = {locks, 10'd0, qres_q, sec_q, pg_err, lk_err, 1'b0, ready};
            A_PARAM:  bus_rdata = 32'(SIZE_SEL & 4'hF);
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = (ctrl_q[0] && ready) || (ctrl_q[2] && lk_err) || (ctrl_q[3] && pg_err);

    p_badkey_r1: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && ready && !cmd.key_ok) |=> (ready && pg_err));
    p_busy_ignore_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && busy) |=> $stable(locks));
    p_locked_r6: assert property (@(posedge clk) disable iff (rst)
        (accept && page_locked && (cmd.op == OP_ERASE_PG || cmd.op == OP_WRITE_PG))
        |=> (lk_err && busy) ##1 !busy);
    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !issue) |=> (!lk_err && !pg_err));
    p_sec_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        sec_q |=> sec_q);
endmodule

// File: tb/flash_cmd_unit_tb_top.sv
module flash_cmd_unit_tb_top;
    localparam int BUSY_LEN = 6;
    localparam int SIZE_SEL = 7;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr, bus_rd;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        irq;
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 0;

    always #4 clk = ~clk;

    flash_cmd_unit #(.SIZE_SEL(SIZE_SEL), .BUSY_LEN(BUSY_LEN)) dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [31:0] mk(input logic [5:0] code, input int page);
        return {8'hA5, 16'(page), 2'b00, code};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic read_status(output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 2'd2;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_ready(output int n);
        logic [31:0] s;
        n = 0;
        peek(2'd2, s);
        while (!s[0] && n < 1000) begin
            @(negedge clk);
            n++;
            peek(2'd2, s);
        end
    endtask

    task automatic run_cmd(input logic [5:0] code, input int page);
        int n;
        bus_write(2'd1, mk(code, page));
        wait_ready(n);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        peek(2'd2, d); check(d == 32'h1, "R2 reset status", d, 32'h1);
        peek(2'd0, d); check(d == 32'h0, "R11 reset ctrl", d, 32'h0);
        peek(2'd3, d); check(d == 32'(SIZE_SEL), "R13 param", d, 32'(SIZE_SEL));
        check(irq == 1'b0, "R12 irq at reset", 32'(irq), 0);
    endtask

    task automatic t_bad_key;
        logic [31:0] d;
        bus_write(2'd1, {8'h5A, 16'd5, 2'b00, 6'd1});
        peek(2'd2, d);
        check(d[0] == 1'b1 && d[3] == 1'b1, "R1 bad key ready/prog err", d, 32'h9);
        read_status(d);
        peek(2'd2, d); check(d[3] == 1'b0, "R10 error cleared by read", d, 32'h1);
        run_cmd(6'd12, 5);
        peek(2'd2, d); check(d[5] == 1'b1, "R1 bad-key write left page erased", d, 32'h21);
    endtask

    task automatic t_erase_write;
        logic [31:0] d;
        int n;
        bus_write(2'd1, mk(6'd1, 5));
        peek(2'd2, d); check(d[0] == 1'b0, "R2 ready low after accept", d, 32'h0);
        wait_ready(n); check(n == BUSY_LEN, "R2 busy length", 32'(n), 32'(BUSY_LEN));
        run_cmd(6'd12, 5);
        peek(2'd2, d); check(d[5] == 1'b0, "R7 written page not erased", d, 32'h1);
        run_cmd(6'd2, 5);
        run_cmd(6'd12, 5);
        peek(2'd2, d); check(d[5] == 1'b1, "R7 erase page", d, 32'h21);
        run_cmd(6'd1, 9);
        run_cmd(6'd6, 0);
        run_cmd(6'd12, 9);
        peek(2'd2, d); check(d[5] == 1'b1, "R7 erase all", d, 32'h21);
    endtask

    task automatic t_busy_ignore;
        logic [31:0] d;
        int n;
        bus_write(2'd1, mk(6'd1, 3));
        bus_write(2'd1, mk(6'd2, 3));
        wait_ready(n);
        run_cmd(6'd12, 3);
        peek(2'd2, d);
        check(d[5] == 1'b0 && d[3] == 1'b0, "R3 command during busy ignored", d, 32'h1);
    endtask

    task automatic t_illegal;
        logic [31:0] d;
        bus_write(2'd1, mk(6'h20, 0));
        peek(2'd2, d); check(d[3] && d[0], "R4 undefined code", d, 32'h9);
        read_status(d);
        bus_write(2'd1, mk(6'd2, 300));
        peek(2'd2, d); check(d[3] && d[0], "R4 page out of range", d, 32'h9);
        read_status(d);
    endtask

    task automatic t_lock;
        logic [31:0] d;
        int n;
        run_cmd(6'd4, 20);
        peek(2'd2, d); check(d[31:16] == 16'h0002, "R5 lock region 1", d, 32'h0002_0001);
        bus_write(2'd1, mk(6'd1, 20));
        peek(2'd2, d); check(d[2] && !d[0], "R6 lock error on write", d, 32'h4);
        wait_ready(n); check(n == 1, "R6 one busy cycle", 32'(n), 1);
        run_cmd(6'd12, 20);
        peek(2'd2, d); check(d[5] == 1'b1, "R6 locked page unchanged", d, 32'h25);
        read_status(d);
        run_cmd(6'd6, 0);
        peek(2'd2, d); check(d[2] == 1'b1, "R6 erase all blocked", d, 32'h4);
        read_status(d);
        run_cmd(6'd5, 31);
        peek(2'd2, d); check(d[31:16] == 16'h0 && d[2] == 1'b0, "R5 unlock via other page", d, 32'h1);
        run_cmd(6'd1, 20);
        run_cmd(6'd12, 20);
        peek(2'd2, d); check(d[5] == 1'b0 && d[2] == 1'b0, "R6 unlocked write runs", d, 32'h1);
    endtask

    task automatic t_user;
        logic [31:0] d;
        run_cmd(6'd13, 0);
        run_cmd(6'd15, 0);
        peek(2'd2, d); check(d[5] == 1'b0, "R8 user page written", d, 32'h1);
        run_cmd(6'd14, 0);
        run_cmd(6'd15, 0);
        peek(2'd2, d); check(d[5] == 1'b1, "R8 user page erased", d, 32'h21);
    endtask

    task automatic t_sec;
        logic [31:0] d;
        run_cmd(6'd9, 0);
        read_status(d); check(d[4] == 1'b1, "R9 security set", d, 32'h10);
        peek(2'd2, d); check(d[4] == 1'b1, "R9 security sticky", d, 32'h10);
    endtask

    task automatic t_ctrl_irq;
        logic [31:0] d;
        int n;
        bus_write(2'd0, 32'hFFFF_FFFF);
        peek(2'd0, d); check(d == 32'hDD, "R11 control mask", d, 32'hDD);
        bus_write(2'd0, 32'h1);
        #1 check(irq == 1'b1, "R12 irq on ready", 32'(irq), 1);
        bus_write(2'd1, mk(6'd0, 0));
        #1 check(irq == 1'b0, "R12 irq low while busy", 32'(irq), 0);
        wait_ready(n);
        #1 check(irq == 1'b1, "R12 irq back on ready", 32'(irq), 1);
        bus_write(2'd0, 32'h4);
        run_cmd(6'd4, 0);
        run_cmd(6'd2, 0);
        #1 check(irq == 1'b1, "R12 irq on lock error", 32'(irq), 1);
        read_status(d);
        #1 check(irq == 1'b0, "R12 irq cleared with error", 32'(irq), 0);
    endtask

    initial begin : watchdog
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_bad_key();
        t_erase_write();
        t_busy_ignore();
        t_illegal();
        t_lock();
        t_user();
        t_sec();
        t_ctrl_irq();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule